// File: doc/BRIEF.md
# Flash Command Security Gate

This block sits between a command source and a flash controller. It holds a device security flag and a per-sector protection mask, and judges every memory command before it goes further. The commands are read, program, sector erase, verify and whole-array erase, and each one names a sector. Every command gets one verdict in the following cycle. The verdict is either a grant or a refusal, and a refusal carries a reason code.

The security flag and the protection mask are taken from configuration inputs while reset is held. After that, only a finished whole-array erase can change them. A finished whole-array erase leaves the device unsecured and with no sector protected. The flash controller reports that an erase has finished with a one-cycle completion pulse. The gate only acts on that pulse when it has itself granted a whole-array erase that has not yet finished.

Top module: `fcmd_gate`

## Requirements
- R1: Each cycle with `req_valid_i` high produces exactly one response, with `rsp_valid_o` high in the next cycle. `rsp_valid_o` stays low in any cycle that does not follow a request.
- R2: A granted response has reason 0. A refused response carries reason 1 (secured), 2 (sector protected) or 3 (invalid request).
- R3: While `rst_n` is low, the security flag is loaded from `cfg_secure_i` and the protection mask from `cfg_protect_i`, and `rsp_valid_o` is low.
- R4: While secured, every opcode other than whole-array erase (opcode 4) is refused with reason 1, for any sector index. This covers read (0), program (1), sector erase (2), verify (3) and the undefined opcodes 5 to 7.
- R5: A whole-array erase (opcode 4) is always granted, whatever the security flag, the protection bits or the sector index.
- R6: While unsecured, an undefined opcode (5 to 7), or a request for opcodes 0 to 3 whose sector index is NUM_SECT or above, is refused with reason 3.
- R7: While unsecured, a sector erase (opcode 2) of a protected sector is refused with reason 2. Read, program and verify of a protected sector are granted.
- R8: If `erase_done_i` is high while a granted whole-array erase is outstanding, the security flag and all protection bits read zero from the next cycle on.
- R9: Apart from reset and R8, the security flag and the protection mask never change. In particular, `erase_done_i` with no outstanding whole-array erase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| cfg_secure_i | input | 1 | Security flag value to load during reset |
| cfg_protect_i | input | NUM_SECT | Protection mask to load during reset, one bit per sector |
| req_valid_i | input | 1 | A command is present this cycle |
| req_op_i | input | 3 | Command opcode |
| req_sector_i | input | SECT_W | Sector index of the command |
| erase_done_i | input | 1 | Whole-array erase has finished (one-cycle pulse) |
| rsp_valid_o | output | 1 | A verdict is present |
| rsp_grant_o | output | 1 | The command is allowed to proceed |
| rsp_why_o | output | 2 | Reason code for the verdict |
| secure_o | output | 1 | Current security flag |
| protect_o | output | NUM_SECT | Current protection mask |

## Verification
The checker makes two assumptions about the inputs:
- The configuration inputs are steady over the last cycles of reset.
- `req_valid_i` and `erase_done_i` are low during reset, so the first cycle after release has no stale history.

The checker judges each verdict against the opcode, sector and state of the cycle before, which holds because every verdict comes one cycle after its command. The bench drives all inputs on the falling edge and holds the configuration fixed while reset is asserted. It pulses the completion input both with and without an outstanding whole-array erase, so that the conditional wipe is exercised from both sides.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_VERIFY = 3'd3,
    OP_CHIP   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    WHY_OK      = 2'd0,
    WHY_SECURED = 2'd1,
    WHY_PROT    = 2'd2,
    WHY_INVALID = 2'd3
  } why_e;

  typedef struct packed {
    logic grant;
    why_e why;
  } verdict_t;

  // Priority: security first, whole-array erase next, then request validity,
  // then sector protection against erasure.
  function automatic verdict_t judge(input logic       secured,
                                     input logic [2:0] op,
                                     input logic       in_range,
                                     input logic       prot_hit);
    verdict_t v;
    v.grant = 1'b0;
    v.why   = WHY_OK;
    if (secured && (op != OP_CHIP)) begin
      v.why = WHY_SECURED;
    end else if (op == OP_CHIP) begin
      v.grant = 1'b1;
    end else if ((op > OP_VERIFY) || !in_range) begin
      v.why = WHY_INVALID;
    end else if ((op == OP_ERASE) && prot_hit) begin
      v.why = WHY_PROT;
    end else begin
      v.grant = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/fcg_state.sv
module fcg_state #(
  parameter int NUM_SECT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_secure_i,
  input  logic [NUM_SECT-1:0] cfg_protect_i,
  input  logic                chip_grant_i,
  input  logic                erase_done_i,
  output logic                secure_o,
  output logic [NUM_SECT-1:0] protect_o,
  output logic                done_evt_o
);

  logic pending_q;

  assign done_evt_o = erase_done_i && pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secure_o  <= cfg_secure_i;
      protect_o <= cfg_protect_i;
      pending_q <= 1'b0;
    end else begin
      if (done_evt_o) begin
        secure_o  <= 1'b0;
        protect_o <= '0;
      end
      pending_q <= chip_grant_i || (pending_q && !erase_done_i);
    end
  end

endmodule

// File: rtl/fcg_judge.sv
module fcg_judge
  import fcg_pkg::*;
#(
  parameter int NUM_SECT = 12,
  parameter int SECT_W   = 4
) (
  input  logic                secure_i,
  input  logic [NUM_SECT-1:0] protect_i,
  input  logic                req_valid_i,
  input  logic [2:0]          req_op_i,
  input  logic [SECT_W-1:0]   req_sector_i,
  output verdict_t            verdict_o,
  output logic                in_range_o,
  output logic                prot_hit_o,
  output logic                chip_grant_o
);

  localparam int PAD_W = 32 - SECT_W;

  assign in_range_o = ({{PAD_W{1'b0}}, req_sector_i} < 32'(NUM_SECT));

  always_comb begin
    prot_hit_o = 1'b0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (req_sector_i == SECT_W'(i)) prot_hit_o = protect_i[i];
    end
  end

  assign verdict_o    = judge(secure_i, req_op_i, in_range_o, prot_hit_o);
  assign chip_grant_o = req_valid_i && verdict_o.grant && (req_op_i == OP_CHIP);

endmodule

// File: rtl/fcg_resp.sv
module fcg_resp
  import fcg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid_i,
  input  verdict_t verdict_i,
  output logic     rsp_valid_o,
  output logic     rsp_grant_o,
  output logic [1:0] rsp_why_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_grant_o <= 1'b0;
      rsp_why_o   <= 2'd0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_grant_o <= verdict_i.grant;
        rsp_why_o   <= verdict_i.why;
      end
    end
  end

endmodule

// File: rtl/fcmd_gate.sv
module fcmd_gate
  import fcg_pkg::*;
#(
  parameter int NUM_SECT = 12,
  parameter int SECT_W   = $clog2(NUM_SECT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_secure_i,
  input  logic [NUM_SECT-1:0] cfg_protect_i,
  input  logic                req_valid_i,
  input  logic [2:0]          req_op_i,
  input  logic [SECT_W-1:0]   req_sector_i,
  input  logic                erase_done_i,
  output logic                rsp_valid_o,
  output logic                rsp_grant_o,
  output logic [1:0]          rsp_why_o,
  output logic                secure_o,
  output logic [NUM_SECT-1:0] protect_o
);

  verdict_t verdict;
  logic     in_range;
  logic     prot_hit;
  logic     chip_grant;
  logic     done_evt;

  fcg_state #(.NUM_SECT(NUM_SECT)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_secure_i (cfg_secure_i),
    .cfg_protect_i(cfg_protect_i),
    .chip_grant_i (chip_grant),
    .erase_done_i (erase_done_i),
    .secure_o     (secure_o),
    .protect_o    (protect_o),
    .done_evt_o   (done_evt)
  );

  fcg_judge #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_judge (
    .secure_i    (secure_o),
    .protect_i   (protect_o),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_sector_i(req_sector_i),
    .verdict_o   (verdict),
    .in_range_o  (in_range),
    .prot_hit_o  (prot_hit),
    .chip_grant_o(chip_grant)
  );

  fcg_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .verdict_i  (verdict),
    .rsp_valid_o(rsp_valid_o),
    .rsp_grant_o(rsp_grant_o),
    .rsp_why_o  (rsp_why_o)
  );

endmodule

// File: rtl/fcmd_gate_chk.sv
module fcmd_gate_chk #(
  parameter int NUM_SECT = 12,
  parameter int SECT_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid_i,
  input logic [2:0]          req_op_i,
  input logic [SECT_W-1:0]   req_sector_i,
  input logic                rsp_valid_o,
  input logic                rsp_grant_o,
  input logic [1:0]          rsp_why_o,
  input logic                secure_o,
  input logic [NUM_SECT-1:0] protect_o,
  input logic                prot_hit,
  input logic                done_evt
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);                                             // R1
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i));                                      // R1
  AST_REASON_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (rsp_grant_o == (rsp_why_o == 2'd0)));                     // R2
  AST_SECURED_ONLY_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_grant_o && $past(secure_o)) |-> ($past(req_op_i) == 3'd4)); // R4
  AST_CHIP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && ($past(req_op_i) == 3'd4)) |-> rsp_grant_o);              // R5
  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_grant_o && ($past(req_op_i) != 3'd4))
      |-> (32'($past(req_sector_i)) < 32'(NUM_SECT)));                        // R6
  AST_PROT_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && ($past(req_op_i) == 3'd2) && $past(prot_hit)) |-> !rsp_grant_o); // R7
  AST_WIPE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!secure_o && (protect_o == '0)));                           // R8
  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(done_evt)) |-> ($stable(secure_o) && $stable(protect_o))); // R9

endmodule

bind fcmd_gate fcmd_gate_chk #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_sector_i(req_sector_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_grant_o (rsp_grant_o),
  .rsp_why_o   (rsp_why_o),
  .secure_o    (secure_o),
  .protect_o   (protect_o),
  .prot_hit    (prot_hit),
  .done_evt    (done_evt)
);

// File: tb/test_fcmd_gate.sv
module test_fcmd_gate;

  localparam int NS = 12;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_secure = 1'b0;
  logic [NS-1:0] cfg_protect = '0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [SW-1:0] req_sector = '0;
  logic          erase_done = 1'b0;
  logic          rsp_valid, rsp_grant;
  logic [1:0]    rsp_why;
  logic          secure;
  logic [NS-1:0] protect;

  fcmd_gate #(.NUM_SECT(NS)) i_fcmd_gate (
    .clk(clk), .rst_n(rst_n), .cfg_secure_i(cfg_secure), .cfg_protect_i(cfg_protect),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_sector_i(req_sector),
    .erase_done_i(erase_done), .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant),
    .rsp_why_o(rsp_why), .secure_o(secure), .protect_o(protect)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit    grant;
    int    why;
    int    due;
    string tag;
  } exp_t;

  exp_t   q[$];
  int     cyc = 0;
  int     n_chk = 0;
  int     n_fail = 0;
  bit     m_sec, m_pend;
  bit [NS-1:0] m_prot;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // monitor: pop and compare verdicts as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "response with nothing expected (actual valid=1, expected 0)");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.due == cyc, e.tag, $sformatf("response cycle actual %0d expected %0d", cyc, e.due));
          chk(rsp_grant == e.grant && int'(rsp_why) == e.why, e.tag,
              $sformatf("verdict actual grant=%0b why=%0d expected grant=%0b why=%0d",
                        rsp_grant, rsp_why, e.grant, e.why));
        end
      end else if (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(1'b0, "R1", $sformatf("%s missing response (actual valid=0, expected 1)", e.tag));
      end
    end
  end

  // driver: one request per call, held until the next call or idle
  task automatic send(input int op, input int sec, input string tag);
    exp_t e;
    e.grant = 1'b0;
    e.why   = 0;
    if (m_sec && op != 4)                  e.why = 1;
    else if (op == 4)                      e.grant = 1'b1;
    else if (op > 3 || sec >= NS)          e.why = 3;
    else if (op == 2 && m_prot[sec])       e.why = 2;
    else                                   e.grant = 1'b1;
    if (e.grant && op == 4) m_pend = 1'b1;
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
    req_valid  = 1'b1;
    req_op     = 3'(op);
    req_sector = SW'(sec);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    chk(secure == m_sec, tag, $sformatf("secure actual %0b expected %0b", secure, m_sec));
    chk(protect == m_prot, tag, $sformatf("protect actual %h expected %h", protect, m_prot));
  endtask

  task automatic pulse_done(input string tag);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    if (m_pend) begin
      m_sec = 1'b0; m_prot = '0; m_pend = 1'b0;
    end
    check_state(tag);
  endtask

  task automatic do_reset(input bit s, input bit [NS-1:0] p);
    rst_n = 1'b0;
    req_valid = 1'b0;
    erase_done = 1'b0;
    cfg_secure = s;
    cfg_protect = p;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R3", $sformatf("rsp_valid in reset actual %0b expected 0", rsp_valid));
    rst_n = 1'b1;
    m_sec = s; m_prot = p; m_pend = 1'b0;
    q.delete();
    @(negedge clk);
    check_state("R3");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog", "run did not complete (actual hung, expected done)");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // secured device
    do_reset(1'b1, 12'h005);
    send(0, 1, "R4 read secured");
    send(1, 3, "R4 program secured");
    send(2, 1, "R4 erase secured");
    send(3, 4, "R4 verify secured");
    send(2, 14, "R4 out-of-range secured");
    send(6, 0, "R4 undefined op secured");
    idle(2);
    pulse_done("R9 stray done");
    idle(1);
    send(4, 9, "R5 chip erase secured");
    send(0, 1, "R4 read before erase done");
    idle(3);
    check_state("R9 hold while pending");
    pulse_done("R8 wipe after chip erase");
    send(0, 1, "R1 read after wipe");
    idle(2);

    // unsecured with protection
    do_reset(1'b0, 12'h0A5);
    send(0, 0, "R7 read protected");
    send(1, 2, "R7 program protected");
    send(2, 2, "R7 erase protected");
    send(2, 1, "R7 erase unprotected");
    send(3, 5, "R7 verify protected");
    send(2, 11, "R7 erase last sector");
    send(0, 12, "R6 sector at limit");
    send(2, 15, "R6 sector max");
    send(5, 3, "R6 undefined op 5");
    send(7, 0, "R6 undefined op 7");
    idle(2);
    check_state("R9 hold unsecured");
    pulse_done("R9 stray done unsecured");
    send(4, 13, "R5 chip erase protected");
    idle(1);
    pulse_done("R8 clear protection");
    send(2, 2, "R8 erase after wipe");
    send(2, 7, "R8 erase after wipe 2");
    idle(3);
    chk(q.size() == 0, "R1", $sformatf("leftover responses actual %0d expected 0", q.size()));
    finish_run();
  end

endmodule